// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where the program counter goes after a branch or call instruction in a 16-bit code space. For each request it receives the address of the instruction after the branch, a branch-kind code, the three address fields an instruction can carry (a signed 8-bit displacement, an 11-bit in-page address and a full 16-bit address), the accumulator and the data pointer. It also receives the condition inputs: carry flag, tested bit, compare result and the counter value after decrementing. It returns the chosen target address, a flag saying whether the branch is taken, and a request to clear the tested bit.

Three address forms are supported. The relative form adds a signed displacement to the following-instruction address. The page form keeps the upper five bits of that address, which select one of 32 pages of 2 KB, and replaces the low eleven bits. The long form loads any address from 0000h to FFFFh. An indexed form adds the zero-extended accumulator to the data pointer. Every conditional kind uses the relative form. A branch that is not taken resolves to the following-instruction address, and all address arithmetic wraps modulo 65536.

Results are registered. A request presented with `inValid` high in one cycle appears on the outputs after the next rising clock edge.

Top module: `branch_target_gen`

## Requirements
- R1: `outValid` is high in the cycle after a cycle with `inValid` high and low otherwise. While `inValid` is low, `outTarget`, `outTaken` and `outClearBit` keep their last values.
- R2: Kind code 1 (unconditional relative) is always taken. Its target is `nextPc` plus `relOffset` read as two's complement, modulo 2^16, so it reaches from -128 to +127 around `nextPc`.
- R3: Kind code 2 (in-page) is always taken. The target's bits 15..11 equal `nextPc[15:11]` and bits 10..0 equal `pageOffset`, so a branch in page 1Fh lands in F800h..FFFFh.
- R4: Kind code 3 (long) is always taken, with target equal to `longTarget` for any value from 0000h to FFFFh.
- R5: Kind code 4 (indexed) is always taken, with target equal to the zero-extended `accValue` plus `dataPtr`, modulo 2^16.
- R6: Kind code 5 is taken when `carryFlag` is 1. Kind code 6 is taken when `carryFlag` is 0.
- R7: Kind code 7 is taken when `accValue` is 00h. Kind code 8 is taken when `accValue` is not 00h.
- R8: Kind codes 9 and 11 are taken when `testedBit` is 1. Kind code 10 is taken when `testedBit` is 0. `outClearBit` is 1 only for a taken kind-11 request.
- R9: Kind code 12 is taken when `cmpDiffers` is 1.
- R10: Kind code 13 is taken when `decValue` (the counter after decrementing) is not 00h.
- R11: A taken conditional kind (5 to 13) targets the relative address of R2. An untaken request, kind code 0, and the unused codes 14 and 15 give `outTaken` = 0 and `outTarget` = `nextPc`.
- R12: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| branchKind | input | 4 | Branch kind code (see requirements) |
| nextPc | input | 16 | Address of the instruction after the branch |
| relOffset | input | 8 | Signed displacement |
| pageOffset | input | 11 | In-page address bits |
| longTarget | input | 16 | Full target address |
| accValue | input | 8 | Accumulator |
| dataPtr | input | 16 | Data pointer |
| carryFlag | input | 1 | Carry flag |
| testedBit | input | 1 | Value of the bit under test |
| cmpDiffers | input | 1 | Compare result, 1 when operands differ |
| decValue | input | 8 | Counter value after decrementing |
| outValid | output | 1 | Result valid |
| outTarget | output | 16 | Resolved next program counter |
| outTaken | output | 1 | Branch taken |
| outClearBit | output | 1 | Clear the tested bit |

## Verification
The bench sweeps all 256 displacements at following-instruction addresses close to 0000h and FFFFh. A design that sign-extended wrongly would send backward branches forward, and one that did not wrap would give a wrong address at the edge of the space. It visits all 32 pages with the lowest and highest in-page values, which catches a slice that is off by one bit or that takes the page from the wrong source. It sweeps every accumulator value against data pointers near the top of memory and every decremented counter value, so it finds a zero test on the wrong operand or a carry-in missing from the indexed add. It applies each condition kind with its condition both true and false, and the reserved codes with every condition true. A swapped polarity, a clear request on a not-taken branch, or a target other than the following address on fall-through each show up as a wrong output.

// File: rtl/branch_target_pkg.sv
package branch_target_pkg;

  typedef enum logic [3:0] {
    KIND_NONE           = 4'd0,
    KIND_SHORT          = 4'd1,
    KIND_PAGE           = 4'd2,
    KIND_LONG           = 4'd3,
    KIND_INDEXED        = 4'd4,
    KIND_IF_CARRY       = 4'd5,
    KIND_IF_NO_CARRY    = 4'd6,
    KIND_IF_ACC_ZERO    = 4'd7,
    KIND_IF_ACC_NONZERO = 4'd8,
    KIND_IF_BIT_SET     = 4'd9,
    KIND_IF_BIT_CLEAR   = 4'd10,
    KIND_IF_BIT_SET_CLR = 4'd11,
    KIND_IF_DIFFERS     = 4'd12,
    KIND_DEC_NONZERO    = 4'd13
  } branchKind_e;

  // Target sources, one-hot selected by the control
  localparam int SRC_FALL = 0;
  localparam int SRC_REL  = 1;
  localparam int SRC_PAGE = 2;
  localparam int SRC_LONG = 3;
  localparam int SRC_IDX  = 4;
  localparam int NUM_SRC  = 5;

  typedef struct packed {
    logic               capture;
    logic               taken;
    logic               clearBit;
    logic [NUM_SRC-1:0] srcSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/btg_control.sv
module btg_control
  import branch_target_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              inValid,
  input  logic [3:0]        branchKind,
  input  logic              carryFlag,
  input  logic [DATA_W-1:0] accValue,
  input  logic              testedBit,
  input  logic              cmpDiffers,
  input  logic [DATA_W-1:0] decValue,
  output ctrlStrobes_t      strobes
);

  branchKind_e kind;
  logic        accZero;
  logic        decZero;
  logic        taken;
  logic        clearReq;
  logic [NUM_SRC-1:0] formSel;

  assign kind    = branchKind_e'(branchKind);
  assign accZero = (accValue == '0);
  assign decZero = (decValue == '0);

  always_comb begin
    taken    = 1'b0;
    clearReq = 1'b0;
    formSel  = '0;
    formSel[SRC_REL] = 1'b1;
    case (kind)
      KIND_SHORT:          taken = 1'b1;
      KIND_PAGE: begin
        taken   = 1'b1;
        formSel = '0;
        formSel[SRC_PAGE] = 1'b1;
      end
      KIND_LONG: begin
        taken   = 1'b1;
        formSel = '0;
        formSel[SRC_LONG] = 1'b1;
      end
      KIND_INDEXED: begin
        taken   = 1'b1;
        formSel = '0;
        formSel[SRC_IDX] = 1'b1;
      end
      KIND_IF_CARRY:       taken = carryFlag;
      KIND_IF_NO_CARRY:    taken = !carryFlag;
      KIND_IF_ACC_ZERO:    taken = accZero;
      KIND_IF_ACC_NONZERO: taken = !accZero;
      KIND_IF_BIT_SET:     taken = testedBit;
      KIND_IF_BIT_CLEAR:   taken = !testedBit;
      KIND_IF_BIT_SET_CLR: begin
        taken    = testedBit;
        clearReq = testedBit;
      end
      KIND_IF_DIFFERS:     taken = cmpDiffers;
      KIND_DEC_NONZERO:    taken = !decZero;
      default:             taken = 1'b0;
    endcase
  end

  always_comb begin
    strobes.capture  = inValid;
    strobes.taken    = taken;
    strobes.clearBit = clearReq;
    if (taken) begin
      strobes.srcSel = formSel;
    end else begin
      strobes.srcSel = '0;
      strobes.srcSel[SRC_FALL] = 1'b1;
    end
  end

endmodule

// File: rtl/btg_datapath.sv
module btg_datapath
  import branch_target_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REL_W     = 8,
  parameter int PAGE_LO_W = 11,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    nextPc,
  input  logic [REL_W-1:0]     relOffset,
  input  logic [PAGE_LO_W-1:0] pageOffset,
  input  logic [ADDR_W-1:0]    longTarget,
  input  logic [DATA_W-1:0]    accValue,
  input  logic [ADDR_W-1:0]    dataPtr,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outTarget,
  output logic                 outTaken,
  output logic                 outClearBit
);

  localparam int REL_EXT_W = ADDR_W - REL_W;
  localparam int PAGE_HI_W = ADDR_W - PAGE_LO_W;
  localparam int IDX_EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] candidate [NUM_SRC];
  logic [ADDR_W-1:0] masked    [NUM_SRC];
  logic [ADDR_W-1:0] picked;

  assign candidate[SRC_FALL] = nextPc;
  assign candidate[SRC_REL]  = nextPc + {{REL_EXT_W{relOffset[REL_W-1]}}, relOffset};
  assign candidate[SRC_PAGE] = {nextPc[ADDR_W-1 -: PAGE_HI_W], pageOffset};
  assign candidate[SRC_LONG] = longTarget;
  assign candidate[SRC_IDX]  = dataPtr + {{IDX_EXT_W{1'b0}}, accValue};

  // One-hot AND-OR selection of the target source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gMask
    assign masked[g] = candidate[g] & {ADDR_W{strobes.srcSel[g]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      picked = picked | masked[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outTarget   <= '0;
      outTaken    <= 1'b0;
      outClearBit <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outTarget   <= picked;
        outTaken    <= strobes.taken;
        outClearBit <= strobes.clearBit;
      end
    end
  end

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import branch_target_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REL_W     = 8,
  parameter int PAGE_LO_W = 11,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [3:0]           branchKind,
  input  logic [ADDR_W-1:0]    nextPc,
  input  logic [REL_W-1:0]     relOffset,
  input  logic [PAGE_LO_W-1:0] pageOffset,
  input  logic [ADDR_W-1:0]    longTarget,
  input  logic [DATA_W-1:0]    accValue,
  input  logic [ADDR_W-1:0]    dataPtr,
  input  logic                 carryFlag,
  input  logic                 testedBit,
  input  logic                 cmpDiffers,
  input  logic [DATA_W-1:0]    decValue,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outTarget,
  output logic                 outTaken,
  output logic                 outClearBit
);

  ctrlStrobes_t strobes;

  btg_control #(.DATA_W(DATA_W)) u_control (
    .inValid    (inValid),
    .branchKind (branchKind),
    .carryFlag  (carryFlag),
    .accValue   (accValue),
    .testedBit  (testedBit),
    .cmpDiffers (cmpDiffers),
    .decValue   (decValue),
    .strobes    (strobes)
  );

  btg_datapath #(
    .ADDR_W(ADDR_W), .REL_W(REL_W), .PAGE_LO_W(PAGE_LO_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .nextPc      (nextPc),
    .relOffset   (relOffset),
    .pageOffset  (pageOffset),
    .longTarget  (longTarget),
    .accValue    (accValue),
    .dataPtr     (dataPtr),
    .outValid    (outValid),
    .outTarget   (outTarget),
    .outTaken    (outTaken),
    .outClearBit (outClearBit)
  );

endmodule

// File: rtl/btg_checker.sv
module btg_checker
  import branch_target_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REL_W     = 8,
  parameter int PAGE_LO_W = 11,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [3:0]           branchKind,
  input logic [ADDR_W-1:0]    nextPc,
  input logic [REL_W-1:0]     relOffset,
  input logic [PAGE_LO_W-1:0] pageOffset,
  input logic [ADDR_W-1:0]    longTarget,
  input logic [DATA_W-1:0]    accValue,
  input logic [ADDR_W-1:0]    dataPtr,
  input logic                 carryFlag,
  input logic                 testedBit,
  input logic                 cmpDiffers,
  input logic [DATA_W-1:0]    decValue,
  input logic                 outValid,
  input logic [ADDR_W-1:0]    outTarget,
  input logic                 outTaken,
  input logic                 outClearBit
);

  localparam int PAGE_HI_W = ADDR_W - PAGE_LO_W;

  logic armed;
  logic signed [ADDR_W-1:0] relSigned;
  logic [ADDR_W-1:0] relRef;
  logic [ADDR_W-1:0] idxRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign relSigned = ADDR_W'($signed(relOffset));
  assign relRef    = nextPc + relSigned;
  assign idxRef    = dataPtr + ADDR_W'(accValue);

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid)));

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(inValid)) |-> ($stable(outTarget) && $stable(outTaken) && $stable(outClearBit)));

  assert_short_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_SHORT)) |-> (outTaken && outTarget == $past(relRef)));

  assert_page_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_PAGE)) |->
      (outTarget[ADDR_W-1 -: PAGE_HI_W] == $past(nextPc[ADDR_W-1 -: PAGE_HI_W]) &&
       outTarget[PAGE_LO_W-1:0] == $past(pageOffset)));

  assert_long_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_LONG)) |-> (outTaken && outTarget == $past(longTarget)));

  assert_indexed_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_INDEXED)) |-> (outTarget == $past(idxRef)));

  assert_carry_cond_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_IF_CARRY)) |-> (outTaken == $past(carryFlag)));

  assert_clear_only_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    outClearBit |-> outTaken);

  assert_clear_cond_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_IF_BIT_SET_CLR)) |-> (outClearBit == $past(testedBit)));

  assert_differs_cond_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_IF_DIFFERS)) |-> (outTaken == $past(cmpDiffers)));

  assert_dec_cond_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && branchKind == KIND_DEC_NONZERO)) |-> (outTaken == ($past(decValue) != '0)));

  assert_fallthrough_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid) && !outTaken) |-> (outTarget == $past(nextPc) && !outClearBit));

  always_comb begin
    if (!rstN) begin
      assert_reset_zero_R12: assert (!outValid && outTarget == '0 && !outTaken && !outClearBit);
    end
  end

endmodule

bind branch_target_gen btg_checker #(
  .ADDR_W(ADDR_W), .REL_W(REL_W), .PAGE_LO_W(PAGE_LO_W), .DATA_W(DATA_W)
) u_btg_checker (.*);

// File: tb/tb_branch_target_gen.sv
`timescale 1ns/1ps
module tb_branch_target_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  branchKind = '0;
  logic [15:0] nextPc = '0;
  logic [7:0]  relOffset = '0;
  logic [10:0] pageOffset = '0;
  logic [15:0] longTarget = '0;
  logic [7:0]  accValue = '0;
  logic [15:0] dataPtr = '0;
  logic        carryFlag = 1'b0;
  logic        testedBit = 1'b0;
  logic        cmpDiffers = 1'b0;
  logic [7:0]  decValue = '0;
  logic        outValid;
  logic [15:0] outTarget;
  logic        outTaken;
  logic        outClearBit;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  branch_target_gen dut (.*);

  task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit condOf(int kind, bit cy, logic [7:0] acc, bit tb, bit ne, logic [7:0] dec);
    case (kind)
      1, 2, 3, 4: return 1'b1;
      5:  return cy;
      6:  return !cy;
      7:  return acc == 8'h00;
      8:  return acc != 8'h00;
      9, 11: return tb;
      10: return !tb;
      12: return ne;
      13: return dec != 8'h00;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one request, check the registered result one cycle later
  task automatic runOne(input int kind, input logic [15:0] npc, input logic [7:0] rel,
                        input logic [10:0] pg, input logic [15:0] lng, input logic [7:0] acc,
                        input logic [15:0] dp, input bit cy, input bit tb, input bit ne,
                        input logic [7:0] dec, input string tag);
    bit tk;
    bit clr;
    logic [15:0] tgt;
    int relInt;
    tk = condOf(kind, cy, acc, tb, ne, dec);
    clr = (kind == 11) && tb;
    relInt = (rel >= 8'd128) ? int'(rel) - 256 : int'(rel);
    if (!tk) tgt = npc;
    else if (kind == 2) tgt = (npc & 16'hF800) | 16'(pg);
    else if (kind == 3) tgt = lng;
    else if (kind == 4) tgt = 16'((int'(dp) + int'(acc)) % 65536);
    else tgt = 16'((int'(npc) + relInt + 65536) % 65536);
    @(negedge clk);
    inValid = 1'b1; branchKind = 4'(kind); nextPc = npc; relOffset = rel;
    pageOffset = pg; longTarget = lng; accValue = acc; dataPtr = dp;
    carryFlag = cy; testedBit = tb; cmpDiffers = ne; decValue = dec;
    @(negedge clk);
    check(outValid && outTarget == tgt && outTaken == tk && outClearBit == clr, tag,
          {outValid, outTaken, outTarget}, {1'b1, tk, tgt});
    if (outClearBit != clr) check(1'b0, {tag, " clear"}, 18'(outClearBit), 18'(clr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] pcs [5];
    logic [15:0] heldTarget;
    pcs[0] = 16'h0000; pcs[1] = 16'h0005; pcs[2] = 16'h7FF0;
    pcs[3] = 16'hFFF0; pcs[4] = 16'h1234;

    // R12: reset state
    repeat (3) @(negedge clk);
    check(!outValid && outTarget == 0 && !outTaken && !outClearBit, "R12 reset",
          {outValid, outTaken, outTarget}, 18'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: full displacement sweep at several bases, including wrap at both ends
    for (int p = 0; p < 5; p++)
      for (int d = 0; d < 256; d++)
        runOne(1, pcs[p], 8'(d), 11'h155, 16'hABCD, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R2 relative");

    // R3: every page, lowest/highest/middle in-page address
    for (int pgn = 0; pgn < 32; pgn++) begin
      runOne(2, 16'(pgn * 2048 + 16'h03C1), 8'h80, 11'h000, 16'h1111, 8'h01, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R3 page low");
      runOne(2, 16'(pgn * 2048 + 16'h07FF), 8'h7F, 11'h7FF, 16'h1111, 8'h01, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R3 page high");
      runOne(2, 16'(pgn * 2048), 8'h00, 11'h2A5, 16'h1111, 8'h01, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R3 page mid");
    end

    // R4: long targets across the space
    for (int k = 0; k < 16; k++)
      runOne(3, 16'h4000, 8'hFE, 11'h3FF, 16'(k * 16'h1111), 8'h00, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R4 long");
    runOne(3, 16'h4000, 8'hFE, 11'h3FF, 16'hFFFF, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R4 long top");

    // R5: every accumulator value against several data pointers, including wrap
    for (int a = 0; a < 256; a++) begin
      runOne(4, 16'h2000, 8'h10, 11'h0, 16'h0, 8'(a), 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, "R5 indexed zero base");
      runOne(4, 16'h2000, 8'h10, 11'h0, 16'h0, 8'(a), 16'hFF80, 1'b0, 1'b0, 1'b0, 8'h00, "R5 indexed wrap");
      runOne(4, 16'h2000, 8'h10, 11'h0, 16'h0, 8'(a), 16'h12F0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 indexed carry");
    end

    // R6: carry conditions, both polarities, forward and backward displacements
    for (int c = 0; c < 2; c++) begin
      runOne(5, 16'h0100, 8'h80, 11'h0, 16'h0, 8'h00, 16'h0, c[0], 1'b0, 1'b0, 8'h00, "R6 if carry back");
      runOne(5, 16'hFFFE, 8'h7F, 11'h0, 16'h0, 8'h00, 16'h0, c[0], 1'b0, 1'b0, 8'h00, "R6 if carry fwd");
      runOne(6, 16'h0100, 8'h80, 11'h0, 16'h0, 8'h00, 16'h0, c[0], 1'b0, 1'b0, 8'h00, "R6 if no carry back");
      runOne(6, 16'h0001, 8'hF0, 11'h0, 16'h0, 8'h00, 16'h0, c[0], 1'b0, 1'b0, 8'h00, "R6 if no carry wrap");
    end

    // R7: accumulator zero tests over every value
    for (int a = 0; a < 256; a++) begin
      runOne(7, 16'h3000, 8'h20, 11'h0, 16'h0, 8'(a), 16'h0, 1'b1, 1'b1, 1'b1, 8'h01, "R7 if acc zero");
      runOne(8, 16'h3000, 8'hE0, 11'h0, 16'h0, 8'(a), 16'h0, 1'b1, 1'b1, 1'b1, 8'h00, "R7 if acc nonzero");
    end

    // R8: bit tests, including clear request
    for (int b = 0; b < 2; b++) begin
      runOne(9,  16'h5555, 8'h03, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, b[0], 1'b0, 8'h00, "R8 if bit set");
      runOne(10, 16'h5555, 8'hFD, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, b[0], 1'b0, 8'h00, "R8 if bit clear");
      runOne(11, 16'h5555, 8'h40, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, b[0], 1'b0, 8'h00, "R8 bit set and clear");
    end

    // R9: compare not-equal
    for (int n = 0; n < 2; n++)
      runOne(12, 16'h8000, 8'hFF, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, 1'b0, n[0], 8'h00, "R9 if differs");

    // R10: decrement-and-branch over every counter value
    for (int v = 0; v < 256; v++)
      runOne(13, 16'h0010, 8'hF8, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0, 8'(v), "R10 dec nonzero");

    // R11: no-branch and reserved codes with every condition true
    foreach (pcs[p]) begin
      runOne(0,  pcs[p], 8'h22, 11'h7FF, 16'hBEEF, 8'h00, 16'h1000, 1'b1, 1'b1, 1'b1, 8'h05, "R11 kind none");
      runOne(14, pcs[p], 8'h22, 11'h7FF, 16'hBEEF, 8'h00, 16'h1000, 1'b1, 1'b1, 1'b1, 8'h05, "R11 reserved 14");
      runOne(15, pcs[p], 8'h22, 11'h7FF, 16'hBEEF, 8'h00, 16'h1000, 1'b1, 1'b1, 1'b1, 8'h05, "R11 reserved 15");
    end

    // R1: idle cycles keep the last result and drop valid
    runOne(11, 16'h6000, 8'h10, 11'h0, 16'h0, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R1 setup");
    heldTarget = 16'h6010;
    @(negedge clk);
    inValid = 1'b0; branchKind = 4'd3; longTarget = 16'h0F0F; testedBit = 1'b0; nextPc = 16'h9999;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!outValid && outTarget == heldTarget && outTaken && outClearBit, "R1 hold while idle",
            {outValid, outTaken, outTarget}, {1'b0, 1'b1, heldTarget});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule